// File: doc/BRIEF.md
# Elastic Wrapper for a Fixed-Schedule Pipelined Unit

This block lets a pipelined arithmetic unit with a compile-time schedule take part in a valid/ready dataflow network. The unit has a fixed latency and a fixed initiation interval. It never waits for valid data: whenever it is enabled it takes whatever sits on its input on the cycles where it signals that it can take an input. The wrapper keeps a record of which of those samples were real data and which were bubbles. It forwards only the results of real data. It freezes the whole unit through its clock enable while a finished result waits for a successor.

The unit's latency does not need to be a multiple of its interval. The validity record holds one bit for each input that can be in flight, which is the latency divided by the interval, rounded up. Several producers are joined, so the unit sees real data only when every producer offers a value. Several consumers each get their own valid signal. That signal is also qualified by a per-output flag from the unit, so a consumer can skip a result it should not receive. A consumer that has already taken its copy during a stall is not offered the same result again.

Top module: `sew_wrap`

## Requirements
- R1: While reset is held, and afterwards until a real input has reached the end of the unit, every output valid is 0. Inputs taken while the joined producer valid is low never produce an output.
- R2: Each output stream carries exactly the results of the accepted real inputs, in acceptance order, with no loss and no duplicate. Here output 0 carries one result for each accepted input.
- R3: Producer i sees ready only when the unit takes an input in that cycle (its ready is high and the clock enable is high) and every other producer is valid, so an input set is consumed as a whole.
- R4: While any output is valid and its consumer is not ready, the clock enable is 0, every producer ready is 0, and in the next cycle that output is still valid with unchanged data.
- R5: Output j is valid only for results whose per-output flag j from the unit is 1. In the test unit, flag 0 is always 1 and flag 1 equals bit 0 of the sum of the two inputs.
- R6: An output that is accepted in a cycle where the clock enable is 0 is not valid in the next cycle.
- R7: The clock enable is 1 in every cycle where no valid output is refused by its consumer.
- R8: Results are matched to their validity bits correctly for a latency that is not a multiple of the interval. The validity record depth is the ceiling of latency over interval; the test unit uses latency 5 and interval 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_IN | Valid from each producer |
| in_data | input | N_IN*IN_W | Data from each producer, producer i at bits i*IN_W |
| in_ready | output | N_IN | Ready to each producer |
| out_valid | output | N_OUT | Valid to each consumer |
| out_data | output | N_OUT*OUT_W | Result to each consumer, consumer j at bits j*OUT_W |
| out_nready | input | N_OUT | Ready from each consumer |
| unit_ce | output | 1 | Clock enable to the scheduled unit |
| unit_din | output | N_IN*IN_W | Joined operand bus to the unit |
| unit_ready | input | 1 | Unit takes an input this cycle if enabled |
| unit_done | input | 1 | Unit presents a completed result |
| unit_oflag | input | N_OUT | Per-output result flag from the unit |
| unit_dout | input | N_OUT*OUT_W | Result bus from the unit |

## Verification
The assertions assume a unit that freezes completely while its clock enable is low, so its done, flags and results do not change. They also assume producers that keep valid and data steady until they see ready. The bench's unit model advances its phase counter and latency chain only on the enable. Its producers drop valid only after a handshake and load fresh data only when idle. The random valid and ready rates are varied across phases, from empty to saturated to heavily back-pressured, so the stall, partial-accept and bubble paths are all reached.

// File: rtl/sew_pkg.sv
package sew_pkg;

   // Number of inputs that can be in flight inside a unit of the given
   // latency that accepts one input every 'interval' cycles.
   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/sew_join.sv
module sew_join #(
   parameter int unsigned N_IN = 2
) (
   input  logic [N_IN-1:0] in_valid,
   input  logic            take,
   output logic            all_valid,
   output logic [N_IN-1:0] in_ready
);

   assign all_valid = &in_valid;

   // A producer is released only when the unit samples and all of its
   // partners are offering data, so input sets are consumed whole.
   for (genvar i = 0; i < N_IN; i++) begin : g_port
      logic [N_IN-1:0] partners;
      assign partners    = in_valid | (N_IN'(1) << i);
      assign in_ready[i] = take & (&partners);
   end

endmodule

// File: rtl/sew_valid_track.sv
module sew_valid_track #(
   parameter int unsigned DEPTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_en,
   input  logic new_bit,
   output logic oldest
);

   if (DEPTH == 1) begin : g_single
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else if (shift_en) begin
            bit_q <= new_bit;
         end
      end
      assign oldest = bit_q;
   end else begin : g_chain
      logic [DEPTH-1:0] bits_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bits_q <= '0;
         end else if (shift_en) begin
            bits_q <= {bits_q[DEPTH-2:0], new_bit};
         end
      end
      assign oldest = bits_q[DEPTH-1];
   end

endmodule

// File: rtl/sew_out_gate.sv
module sew_out_gate #(
   parameter int unsigned N_OUT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic             oldest,
   input  logic [N_OUT-1:0] oflag,
   input  logic [N_OUT-1:0] nready,
   output logic [N_OUT-1:0] out_valid,
   output logic             ce
);

   logic [N_OUT-1:0] sent_q;
   logic [N_OUT-1:0] pend;

   assign pend      = {N_OUT{done & oldest}} & oflag & ~sent_q;
   assign out_valid = pend;
   // Freeze the unit while any offered copy is still refused.
   assign ce        = &(~pend | nready);

   // Remember consumers already served while the unit is frozen.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sent_q <= '0;
      end else if (ce) begin
         sent_q <= '0;
      end else begin
         sent_q <= sent_q | (pend & nready);
      end
   end

endmodule

// File: rtl/sew_wrap.sv
module sew_wrap #(
   parameter int unsigned N_IN    = 2,
   parameter int unsigned IN_W    = 8,
   parameter int unsigned N_OUT   = 2,
   parameter int unsigned OUT_W   = 8,
   parameter int unsigned LATENCY = 5,
   parameter int unsigned II      = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_IN-1:0]        in_valid,
   input  logic [N_IN*IN_W-1:0]   in_data,
   output logic [N_IN-1:0]        in_ready,
   output logic [N_OUT-1:0]       out_valid,
   output logic [N_OUT*OUT_W-1:0] out_data,
   input  logic [N_OUT-1:0]       out_nready,
   output logic                   unit_ce,
   output logic [N_IN*IN_W-1:0]   unit_din,
   input  logic                   unit_ready,
   input  logic                   unit_done,
   input  logic [N_OUT-1:0]       unit_oflag,
   input  logic [N_OUT*OUT_W-1:0] unit_dout
);

   localparam int unsigned DEPTH = sew_pkg::ceil_div(LATENCY, II);

   if (LATENCY < 1) begin : g_bad_lat
      $error("sew_wrap: LATENCY must be at least 1");
   end
   if (II < 1) begin : g_bad_ii
      $error("sew_wrap: II must be at least 1");
   end
   if (N_IN < 1 || N_OUT < 1) begin : g_bad_ports
      $error("sew_wrap: needs at least one input and one output");
   end
   if (IN_W < 1 || OUT_W < 1) begin : g_bad_width
      $error("sew_wrap: data widths must be non-zero");
   end

   logic take;
   logic joined_valid;
   logic oldest;

   assign take     = unit_ready & unit_ce;
   assign unit_din = in_data;
   assign out_data = unit_dout;

   sew_join #(.N_IN(N_IN)) join_i (
      .in_valid  (in_valid),
      .take      (take),
      .all_valid (joined_valid),
      .in_ready  (in_ready)
   );

   sew_valid_track #(.DEPTH(DEPTH)) track_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (take),
      .new_bit  (joined_valid),
      .oldest   (oldest)
   );

   sew_out_gate #(.N_OUT(N_OUT)) gate_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (unit_done),
      .oldest    (oldest),
      .oflag     (unit_oflag),
      .nready    (out_nready),
      .out_valid (out_valid),
      .ce        (unit_ce)
   );

endmodule

// File: rtl/sew_checker.sv
module sew_checker #(
   parameter int unsigned N_IN  = 2,
   parameter int unsigned N_OUT = 2,
   parameter int unsigned OUT_W = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [N_IN-1:0]        in_valid,
   input logic [N_IN-1:0]        in_ready,
   input logic [N_OUT-1:0]       out_valid,
   input logic [N_OUT*OUT_W-1:0] out_data,
   input logic [N_OUT-1:0]       out_nready,
   input logic                   unit_ce
);

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_quiet_in_reset_R1: assert (out_valid == '0);
      end
   end

   assert_stall_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_valid & ~out_nready) != '0) |-> (!unit_ce && in_ready == '0));

   assert_free_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_valid & ~out_nready) == '0) |-> unit_ce);

   for (genvar i = 0; i < N_IN; i++) begin : g_in
      assert_join_whole_R3: assert property (@(posedge clk) disable iff (!rst_n)
         in_ready[i] |-> (&(in_valid | (N_IN'(1) << i))));
   end

   for (genvar j = 0; j < N_OUT; j++) begin : g_out
      assert_hold_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[j] && !out_nready[j]) |=>
            (out_valid[j] && $stable(out_data[j*OUT_W +: OUT_W])));
      assert_no_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[j] && out_nready[j] && !unit_ce) |=> !out_valid[j]);
   end

endmodule

bind sew_wrap sew_checker #(
   .N_IN  (N_IN),
   .N_OUT (N_OUT),
   .OUT_W (OUT_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_data   (out_data),
   .out_nready (out_nready),
   .unit_ce    (unit_ce)
);

// File: tb/sew_wrap_tb_top.sv
module sew_model_unit #(
   parameter int LAT = 5,
   parameter int II  = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ce,
   input  logic [15:0] din,
   output logic        ready,
   output logic        done,
   output logic [1:0]  oflag,
   output logic [15:0] dout
);
   int          phase;
   logic        tag [LAT];
   logic [15:0] dat [LAT];
   logic [7:0]  a, b, s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= 0;
         for (int k = 0; k < LAT; k++) begin
            tag[k] <= 1'b0;
            dat[k] <= '0;
         end
      end else if (ce) begin
         phase  <= (phase == II - 1) ? 0 : phase + 1;
         tag[0] <= ready;
         dat[0] <= din;
         for (int k = 1; k < LAT; k++) begin
            tag[k] <= tag[k-1];
            dat[k] <= dat[k-1];
         end
      end
   end

   assign ready = (phase == 0);
   assign done  = tag[LAT-1];
   assign a     = dat[LAT-1][7:0];
   assign b     = dat[LAT-1][15:8];
   assign s     = a + b;
   assign dout  = {a ^ b, s};
   assign oflag = {s[0], 1'b1};
endmodule

module sew_wrap_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LAT = 5;
   localparam int II  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  in_valid = '0;
   logic [15:0] in_data = '0;
   logic [1:0]  in_ready;
   logic [1:0]  out_valid;
   logic [15:0] out_data;
   logic [1:0]  out_nready = '0;
   logic        unit_ce;
   logic [15:0] unit_din;
   logic        unit_ready;
   logic        unit_done;
   logic [1:0]  unit_oflag;
   logic [15:0] unit_dout;

   always #(CLK_PERIOD/2) clk = ~clk;

   sew_wrap #(.N_IN(2), .IN_W(8), .N_OUT(2), .OUT_W(8), .LATENCY(LAT), .II(II)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_nready(out_nready),
      .unit_ce(unit_ce), .unit_din(unit_din), .unit_ready(unit_ready),
      .unit_done(unit_done), .unit_oflag(unit_oflag), .unit_dout(unit_dout)
   );

   sew_model_unit #(.LAT(LAT), .II(II)) unit_i (
      .clk(clk), .rst_n(rst_n), .ce(unit_ce), .din(unit_din),
      .ready(unit_ready), .done(unit_done), .oflag(unit_oflag), .dout(unit_dout)
   );

   int checks = 0;
   int errors = 0;
   logic [7:0] exp0 [$];
   logic [7:0] exp1 [$];
   logic       hold_v [2];
   logic [7:0] hold_d [2];
   logic       fired  [2];
   logic [1:0] prev_refused = '0;
   logic [15:0] prev_data = '0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic run_phase(input int cycles, input int pct_valid, input int pct_ready);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         for (int i = 0; i < 2; i++) begin
            if (fired[i]) hold_v[i] = 1'b0;
            if (!hold_v[i] && ($urandom_range(99) < pct_valid)) begin
               hold_v[i] = 1'b1;
               hold_d[i] = 8'($urandom);
            end
            in_valid[i] = hold_v[i];
         end
         in_data = {hold_d[1], hold_d[0]};
         for (int j = 0; j < 2; j++) out_nready[j] = ($urandom_range(99) < pct_ready);
         #1;
         // R3: a producer is released only together with its partner
         for (int i = 0; i < 2; i++) begin
            fired[i] = in_valid[i] & in_ready[i];
            if (in_ready[i]) check(in_valid[1-i] == 1'b1, "R3 join", in_valid[1-i], 1);
         end
         check(fired[0] == fired[1], "R3 whole set", fired[0], fired[1]);
         if (fired[0]) begin
            logic [7:0] s;
            s = hold_d[0] + hold_d[1];
            exp0.push_back(s);
            if (s[0]) exp1.push_back(hold_d[0] ^ hold_d[1]);
         end
         // R4 / R7: enable follows refused outputs
         if ((out_valid & ~out_nready) != '0) begin
            check(unit_ce == 1'b0, "R4 enable", unit_ce, 0);
            check(in_ready == 2'b00, "R4 ready", in_ready, 0);
         end else begin
            check(unit_ce == 1'b1, "R7 enable", unit_ce, 1);
         end
         // R4: refused output held with same data
         for (int j = 0; j < 2; j++) begin
            if (prev_refused[j]) begin
               check(out_valid[j] == 1'b1, "R4 held valid", out_valid[j], 1);
               check(out_data[j*8 +: 8] == prev_data[j*8 +: 8], "R4 held data",
                     out_data[j*8 +: 8], prev_data[j*8 +: 8]);
            end
         end
         // R2 R5 R6 R8: stream contents in order
         if (out_valid[0]) begin
            if (exp0.size() == 0) check(1'b0, "R2 R6 output0 extra", out_data[7:0], -1);
            else begin
               check(out_data[7:0] == exp0[0], "R2 R8 output0", out_data[7:0], exp0[0]);
               if (out_nready[0]) void'(exp0.pop_front());
            end
         end
         if (out_valid[1]) begin
            if (exp1.size() == 0) check(1'b0, "R5 R6 output1 extra", out_data[15:8], -1);
            else begin
               check(out_data[15:8] == exp1[0], "R5 R6 output1", out_data[15:8], exp1[0]);
               if (out_nready[1]) void'(exp1.pop_front());
            end
         end
         prev_refused = out_valid & ~out_nready;
         prev_data    = out_data;
      end
   endtask

   initial begin
      for (int i = 0; i < 2; i++) begin
         hold_v[i] = 1'b0;
         hold_d[i] = '0;
         fired[i]  = 1'b0;
      end
      // R1: quiet during reset even with inputs offered
      in_valid   = 2'b11;
      in_data    = 16'h0304;
      out_nready = 2'b11;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         check(out_valid == 2'b00, "R1 reset", out_valid, 0);
      end
      in_valid = 2'b00;
      @(negedge clk);
      rst_n = 1'b1;
      // R1: bubbles only, nothing emitted
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         #1;
         check(out_valid == 2'b00, "R1 bubbles", out_valid, 0);
      end
      run_phase(1500, 40, 70);   // mixed traffic
      run_phase(800, 100, 100);  // saturated, no back-pressure
      run_phase(1500, 80, 25);   // heavy back-pressure
      run_phase(800, 15, 90);    // sparse input
      run_phase(80, 0, 100);     // drain
      check(exp0.size() == 0, "R2 no loss output0", exp0.size(), 0);
      check(exp1.size() == 0, "R5 no loss output1", exp1.size(), 0);
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end
endmodule